// File: doc/BRIEF.md
# Indirect-Addressed GPIO Port Controller

An 8-bit general-purpose I/O port whose pin configuration lives in a small set of sub-registers that are not directly addressable. The bus sees four registers: output data, pin input, a sub-register index, and a window. Software first loads the index with the number of the sub-register it wants. It then reads or writes that sub-register through the window. The index is not changed by window accesses, so a sequence of window accesses all reach the same sub-register.

The sub-registers hold, for each pin:
- direction;
- alternate-function ownership;
- open-drain mode;
- high-current drive request.

The pin drive logic merges these with the port output data and with the output value and enable that an alternate peripheral supplies. From them it produces per-pin output-enable, output-value and high-drive signals for a pad wrapper. Open-drain and high-drive act on the pin whether the port or the alternate function owns it. Pin levels return through a two-flop synchronizer to a read-only input register.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset, the output data, index, alternate-function, open-drain and high-drive registers read 00h and direction reads FFh. With those values pad_oe is 00h.
- R2: Bus register codes on bus_sel are 0 = output data, 1 = pin input, 2 = sub-register index, 3 = window. A write takes effect at the next rising clock edge. bus_rdata shows the selected register combinationally. A window access reads or writes the sub-register named by the index. The index keeps its value across window accesses.
- R3: Sub-register index 01h is direction, 02h is alternate-function enable, 03h is open-drain and 04h is high-drive. Any other index reads 00h through the window, and window writes to it change no sub-register.
- R4: When a pin's alternate-function bit is 0, its output enable is the inverse of its direction bit (1 = input), and its output value is its output-data bit.
- R5: When a pin's alternate-function bit is 1, its output enable and output value come from alt_oe and alt_out for that pin. The direction and output-data bits have no effect on it.
- R6: When a pin's open-drain bit is 1, pad_do for that pin is 0, and pad_oe is the chosen enable ANDed with the inverse of the chosen value. This holds under both port and alternate-function ownership.
- R7: pad_hd for each pin equals its high-drive bit, whoever owns the pin.
- R8: The pin input register returns pin_in as sampled two rising edges earlier. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Bus register select (0 data, 1 pin input, 2 index, 3 window) |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| pin_in | input | 8 | Pad input levels, asynchronous |
| alt_out | input | 8 | Output value from the alternate peripheral |
| alt_oe | input | 8 | Output enable from the alternate peripheral |
| pad_oe | output | 8 | Per-pin pad output enable |
| pad_do | output | 8 | Per-pin pad output value |
| pad_hd | output | 8 | Per-pin high-current drive request |

## Verification
The hardest case to reach is a port that is split between owners and modes at the same time. In it, some pins belong to the alternate function, some belong to the port, and open-drain is set on a pattern that cuts across both groups. Every one of these settings has to be placed through the indirect window, one index write and one window write per sub-register. The bench programs each vector of its table this way, including vectors with mixed nibble patterns, before it compares the pad outputs. Directed sequences then check that the index survives repeated window accesses, and that unassigned indices leave all four sub-registers intact.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned PORT_W = 8;
    localparam int unsigned IDX_W  = 8;

    typedef logic [PORT_W-1:0] pvec_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {
        REG_DOUT   = 2'd0,
        REG_PIN    = 2'd1,
        REG_INDEX  = 2'd2,
        REG_WINDOW = 2'd3
    } bus_reg_e;

    localparam idx_t SUB_DIR = 8'h01;
    localparam idx_t SUB_AFN = 8'h02;
    localparam idx_t SUB_ODR = 8'h03;
    localparam idx_t SUB_HDR = 8'h04;

    typedef struct packed {
        pvec_t dir;
        pvec_t afn;
        pvec_t odr;
        pvec_t hdr;
    } port_cfg_t;

    localparam port_cfg_t CFG_RESET = '{dir: '1, afn: '0, odr: '0, hdr: '0};

    typedef struct packed {
        logic en;
        logic val;
    } drive_t;

    function automatic logic idx_known(idx_t idx);
        return (idx == SUB_DIR) || (idx == SUB_AFN) ||
               (idx == SUB_ODR) || (idx == SUB_HDR);
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_reg_e  sel,
    input  logic      we,
    input  pvec_t     wdata,
    output port_cfg_t cfg,
    output pvec_t     dout,
    output idx_t      index,
    output pvec_t     window_rdata
);

    logic win_wr;
    assign win_wr = we && (sel == REG_WINDOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RESET;
            dout  <= '0;
            index <= '0;
        end else if (we) begin
            unique case (sel)
                REG_DOUT:  dout  <= wdata;
                REG_INDEX: index <= idx_t'(wdata);
                REG_WINDOW: begin
                    if (index == SUB_DIR) cfg.dir <= wdata;
                    if (index == SUB_AFN) cfg.afn <= wdata;
                    if (index == SUB_ODR) cfg.odr <= wdata;
                    if (index == SUB_HDR) cfg.hdr <= wdata;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        window_rdata = '0;
        if (index == SUB_DIR) window_rdata = cfg.dir;
        if (index == SUB_AFN) window_rdata = cfg.afn;
        if (index == SUB_ODR) window_rdata = cfg.odr;
        if (index == SUB_HDR) window_rdata = cfg.hdr;
    end

    p_reset_vals_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (cfg.dir == '1) && (cfg.odr == '0) && (index == '0));

    p_index_hold_r2: assert property (@(posedge clk) disable iff (rst)
        win_wr |=> $stable(index));

    p_window_odr_r2: assert property (@(posedge clk) disable iff (rst)
        win_wr && (index == SUB_ODR) |=> cfg.odr == $past(wdata));

    p_unknown_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        win_wr && !idx_known(index) |=> $stable(cfg));

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_cfg_t cfg,
    input  pvec_t     dout,
    input  pvec_t     alt_out,
    input  pvec_t     alt_oe,
    output pvec_t     pad_oe,
    output pvec_t     pad_do,
    output pvec_t     pad_hd
);

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        drive_t chosen;

        always_comb begin
            if (cfg.afn[i]) begin
                chosen.en  = alt_oe[i];
                chosen.val = alt_out[i];
            end else begin
                chosen.en  = ~cfg.dir[i];
                chosen.val = dout[i];
            end
        end

        always_comb begin
            if (cfg.odr[i]) begin
                pad_oe[i] = chosen.en & ~chosen.val;
                pad_do[i] = 1'b0;
            end else begin
                pad_oe[i] = chosen.en;
                pad_do[i] = chosen.val;
            end
        end

        assign pad_hd[i] = cfg.hdr[i];

        p_od_never_high_r6: assert property (@(posedge clk) disable iff (rst)
            cfg.odr[i] |-> !(pad_oe[i] && pad_do[i]));

        p_port_owned_input_r4: assert property (@(posedge clk) disable iff (rst)
            !cfg.afn[i] && cfg.dir[i] |-> !pad_oe[i]);
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_port_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pvec_t d,
    output pvec_t q
);

    pvec_t stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s - 1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_sel,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] pin_in,
    input  logic [7:0] alt_out,
    input  logic [7:0] alt_oe,
    output logic [7:0] pad_oe,
    output logic [7:0] pad_do,
    output logic [7:0] pad_hd
);

    bus_reg_e  sel;
    port_cfg_t cfg;
    pvec_t     dout;
    idx_t      index;
    pvec_t     win_rd;
    pvec_t     pin_sync;

    assign sel = bus_reg_e'(bus_sel);

    gpio_cfg_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .sel          (sel),
        .we           (bus_we),
        .wdata        (bus_wdata),
        .cfg          (cfg),
        .dout         (dout),
        .index        (index),
        .window_rdata (win_rd)
    );

    gpio_pin_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .dout    (dout),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_oe  (pad_oe),
        .pad_do  (pad_do),
        .pad_hd  (pad_hd)
    );

    gpio_in_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    always_comb begin
        unique case (sel)
            REG_DOUT:   bus_rdata = dout;
            REG_PIN:    bus_rdata = pin_sync;
            REG_INDEX:  bus_rdata = pvec_t'(index);
            REG_WINDOW: bus_rdata = win_rd;
            default:    bus_rdata = '0;
        endcase
    end

    p_pin_ro_r8: assert property (@(posedge clk) disable iff (rst)
        bus_we && (sel == REG_PIN) |=> $stable(dout) && $stable(index) && $stable(cfg));

endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_sel;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in;
    logic [7:0] alt_out;
    logic [7:0] alt_oe;
    logic [7:0] pad_oe;
    logic [7:0] pad_do;
    logic [7:0] pad_hd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gpio_port_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .alt_out(alt_out), .alt_oe(alt_oe), .pad_oe(pad_oe),
        .pad_do(pad_do), .pad_hd(pad_hd)
    );

    // dir, afn, odr, hdr, dout, alt_out, alt_oe, exp_oe, exp_do, exp_hd
    typedef struct packed {
        logic [7:0] dir, afn, odr, hdr, dout, aout, aoe, e_oe, e_do, e_hd;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'hA5, 8'h00, 8'h00, 8'hFF, 8'hA5, 8'h00}, // R4
        '{8'hF0, 8'h00, 8'h00, 8'h0F, 8'h3C, 8'hFF, 8'hFF, 8'h0F, 8'h3C, 8'h0F}, // R4 R7
        '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h96, 8'hF0, 8'hF0, 8'h96, 8'h00}, // R5
        '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h5A, 8'h00, 8'h00, 8'hA5, 8'h00, 8'hFF}, // R6 R7
        '{8'h00, 8'hFF, 8'hFF, 8'hAA, 8'h00, 8'hC3, 8'hFF, 8'h3C, 8'h00, 8'hAA}, // R6 R7
        '{8'h0F, 8'hF0, 8'hCC, 8'h00, 8'h66, 8'hA5, 8'h3C, 8'h30, 8'h22, 8'h00}, // R5 R6
        '{8'h55, 8'h0F, 8'h0F, 8'h81, 8'hFF, 8'h0F, 8'h0F, 8'hA0, 8'hF0, 8'h81}  // R5 R6 R7
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, output logic [7:0] d);
        bus_sel = s;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr_sub(logic [7:0] idx, logic [7:0] d);
        wr(2'd2, idx);
        wr(2'd3, d);
    endtask

    task automatic chk_sub(string req, logic [7:0] idx, logic [7:0] exp);
        logic [7:0] v;
        wr(2'd2, idx);
        rd(2'd3, v);
        check(req, v, exp);
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; bus_sel = 2'd0; bus_we = 1'b0; bus_wdata = '0;
        pin_in = 8'h00; alt_out = 8'hFF; alt_oe = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        rd(2'd0, v); check("R1 dout", v, 8'h00);
        rd(2'd2, v); check("R1 index", v, 8'h00);
        chk_sub("R1 dir", 8'h01, 8'hFF);
        chk_sub("R1 afn", 8'h02, 8'h00);
        chk_sub("R1 odr", 8'h03, 8'h00);
        chk_sub("R1 hdr", 8'h04, 8'h00);

        // Vector table walk (R4 R5 R6 R7)
        for (int k = 0; k < NV; k++) begin
            wr_sub(8'h01, VECS[k].dir);
            wr_sub(8'h02, VECS[k].afn);
            wr_sub(8'h03, VECS[k].odr);
            wr_sub(8'h04, VECS[k].hdr);
            wr(2'd0, VECS[k].dout);
            alt_out = VECS[k].aout;
            alt_oe  = VECS[k].aoe;
            #1;
            check($sformatf("R4/R5/R6 oe vec%0d", k), pad_oe, VECS[k].e_oe);
            check($sformatf("R4/R5/R6 do vec%0d", k), pad_do, VECS[k].e_do);
            check($sformatf("R7 hd vec%0d", k), pad_hd, VECS[k].e_hd);
        end

        // R2 index held across repeated window accesses
        wr(2'd2, 8'h03);
        wr(2'd3, 8'h5A);
        rd(2'd3, v); check("R2 window read 1", v, 8'h5A);
        wr(2'd3, 8'hC3);
        rd(2'd3, v); check("R2 window read 2", v, 8'hC3);
        rd(2'd2, v); check("R2 index kept", v, 8'h03);
        chk_sub("R2 other sub untouched", 8'h04, 8'h81);

        // R3 unassigned indices
        wr_sub(8'h00, 8'hFF);
        rd(2'd3, v); check("R3 idx00 reads zero", v, 8'h00);
        wr_sub(8'h07, 8'h3E);
        rd(2'd3, v); check("R3 idx07 reads zero", v, 8'h00);
        wr_sub(8'h83, 8'h11);
        rd(2'd3, v); check("R3 idx83 reads zero", v, 8'h00);
        chk_sub("R3 dir intact", 8'h01, 8'h55);
        chk_sub("R3 afn intact", 8'h02, 8'h0F);
        chk_sub("R3 odr intact", 8'h03, 8'hC3);
        chk_sub("R3 hdr intact", 8'h04, 8'h81);

        // R8 input synchronizer latency and read-only
        bus_sel = 2'd1;
        @(negedge clk);
        pin_in = 8'hB7;
        @(negedge clk);
        rd(2'd1, v); check("R8 after one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd1, v); check("R8 after two edges", v, 8'hB7);
        wr(2'd1, 8'h24);
        rd(2'd1, v); check("R8 write ignored", v, 8'hB7);
        rd(2'd0, v); check("R8 dout unchanged", v, 8'hFF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule